// File: doc/BRIEF.md
# PTM Time Value Deserializer

This block sits next to a PCIe endpoint controller and takes in the Precision Time Measurement timing that the controller sends on a sideband wire interface. Everything runs in the controller's clock domain. A one-cycle start strobe marks the start of a frame. After it, two serial lanes each carry a 64-bit word, least significant bit first, over 64 consecutive cycles. One lane carries the new PTM clock value. The other carries the amount by which that value was corrected.

The block puts both lanes into shift registers. Once the last bit is in, it latches the two parallel words and raises a result-valid pulse for one cycle. It drops a frame if the controller's context-valid flag is low at the strobe or goes low at any point during the frame. A strobe that arrives in the middle of a frame starts a new frame, and the partial one is discarded.

A local time counter normally counts up by one per cycle. On each result-valid it loads the captured clock value plus a fixed latency constant. An application command produces a single-cycle manual update request toward the controller. Further commands are ignored until a frame completes or a programmable timeout expires.

Top module: `ptm_deser`

## Requirements
- R1: After reset, result_valid_o, manual_req_o, clk_val_o, corr_val_o and local_time_o are all zero, and the request generator is armed.
- R2: The serial bit sampled i cycles after the strobe cycle (i = 0..63) ends up in bit i of clk_val_o. result_valid_o is high only in the single cycle that follows the 64th bit.
- R3: The correction lane is sampled in the same cycles as the clock lane and appears on corr_val_o in the same cycle as clk_val_o.
- R4: If ctx_valid_i is low in the strobe cycle, the frame is dropped. No result-valid is raised and both output words keep their previous values.
- R5: If ctx_valid_i goes low in any cycle of the 64-bit frame, the frame is dropped. No result-valid is raised and both output words keep their previous values.
- R6: A strobe during a frame restarts bit collection from that strobe. The partial frame never produces a result-valid.
- R7: A manual command while armed produces manual_req_o high for exactly one cycle, in the cycle after the command is sampled.
- R8: After a request, commands produce no request until a frame completes (result_valid_o).
- R9: After a request, the generator re-arms once timeout_i clock edges have passed since the request was registered, even if no frame has completed.
- R10: local_time_o increases by one every cycle in which result_valid_o is low.
- R11: In the cycle after result_valid_o, local_time_o equals the captured clock value plus LAT_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared with the controller |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctx_valid_i | input | 1 | Controller's PTM context is valid |
| start_i | input | 1 | One-cycle strobe; marks the first bit of a frame |
| clk_bit_i | input | 1 | Serial PTM clock value, LSB first |
| corr_bit_i | input | 1 | Serial correction value, LSB first |
| manual_cmd_i | input | 1 | Application asks for a manual time update |
| timeout_i | input | TMO_W | Number of cycles after which the request generator re-arms |
| clk_val_o | output | WORD_W | Last captured PTM clock value |
| corr_val_o | output | WORD_W | Last captured correction value |
| result_valid_o | output | 1 | One-cycle pulse when both words are updated |
| manual_req_o | output | 1 | One-cycle manual update request to the controller |
| local_time_o | output | WORD_W | Local time counter |

## Verification
The hardest conditions to reach are the ones where a frame almost completes and must still be dropped. Examples are a context-valid drop on the very last bit, and a second strobe that lands within an already running frame. The bench drives every bit from a frame task that takes a drop position and a start-context flag. It also uses a partial-frame task that is cut short by a fresh strobe. It checks after every bit that result-valid stays low and that the output words still hold the previous frame. Re-arming the request generator is reached two ways: with a long timeout and a completed frame, and with a short timeout and no frame.

// File: rtl/ptm_deser_pkg.sv
package ptm_deser_pkg;
  typedef enum logic {FR_IDLE = 1'b0, FR_RUN = 1'b1} fr_state_e;
  localparam int unsigned N_LANES = 2;
  localparam int unsigned LANE_CLK = 0;
  localparam int unsigned LANE_CORR = 1;
endpackage

// File: rtl/ptm_frame_ctrl.sv
module ptm_frame_ctrl
  import ptm_deser_pkg::*;
#(
  parameter int unsigned WORD_W = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ctx_valid_i,
  output logic shift_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  fr_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      // bit 0 is taken in the strobe cycle
      state_q <= ctx_valid_i ? FR_RUN : FR_IDLE;
      cnt_q   <= CNT_W'(1);
    end else if (state_q == FR_RUN) begin
      if (!ctx_valid_i || cnt_q == LAST) state_q <= FR_IDLE;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign shift_o = start_i || (state_q == FR_RUN);
  assign done_o  = (state_q == FR_RUN) && !start_i && ctx_valid_i && (cnt_q == LAST);

  assert_start_no_ctx_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !ctx_valid_i |=> state_q == FR_IDLE);
  assert_drop_mid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FR_RUN) && !start_i && !ctx_valid_i |=> state_q == FR_IDLE);
  assert_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && ctx_valid_i |=> cnt_q == CNT_W'(1) && state_q == FR_RUN);
endmodule

// File: rtl/ptm_lane.sv
module ptm_lane #(
  parameter int unsigned WORD_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              cap_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      word_q <= '0;
    end else begin
      if (shift_i) sr_q <= {bit_i, sr_q[WORD_W-1:1]};
      // last bit goes straight into the result
      if (cap_i) word_q <= {bit_i, sr_q[WORD_W-1:1]};
    end
  end

  assign word_o = word_q;

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(word_q));
endmodule

// File: rtl/ptm_req_gen.sv
module ptm_req_gen #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_i,
  input  logic             rearm_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             req_o
);
  logic             armed_q;
  logic             req_q;
  logic [TMO_W-1:0] wait_q;
  logic [TMO_W-1:0] wait_nx;

  assign wait_nx = (&wait_q) ? wait_q : wait_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      req_q   <= 1'b0;
      wait_q  <= '0;
    end else begin
      req_q <= cmd_i && armed_q;
      if (cmd_i && armed_q) begin
        armed_q <= 1'b0;
        wait_q  <= '0;
      end else if (!armed_q) begin
        wait_q <= wait_nx;
        if (rearm_i || wait_nx >= timeout_i) armed_q <= 1'b1;
      end
    end
  end

  assign req_o = req_q;

  assert_req_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  assert_req_needs_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i |=> !req_q);
  assert_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> !req_q);
endmodule

// File: rtl/ptm_time_cnt.sv
module ptm_time_cnt #(
  parameter int unsigned WORD_W  = 64,
  parameter int unsigned LAT_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] value_i,
  output logic [WORD_W-1:0] time_o
);
  localparam logic [WORD_W-1:0] LAT = WORD_W'(LAT_CYC);

  logic [WORD_W-1:0] time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     time_q <= '0;
    else if (load_i) time_q <= value_i + LAT;
    else             time_q <= time_q + 1'b1;
  end

  assign time_o = time_q;

  assert_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> time_q == $past(time_q) + 1'b1);
  assert_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> time_q == $past(value_i) + LAT);
endmodule

// File: rtl/ptm_deser.sv
module ptm_deser
  import ptm_deser_pkg::*;
#(
  parameter int unsigned WORD_W  = 64,
  parameter int unsigned TMO_W   = 16,
  parameter int unsigned LAT_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctx_valid_i,
  input  logic              start_i,
  input  logic              clk_bit_i,
  input  logic              corr_bit_i,
  input  logic              manual_cmd_i,
  input  logic [TMO_W-1:0]  timeout_i,
  output logic [WORD_W-1:0] clk_val_o,
  output logic [WORD_W-1:0] corr_val_o,
  output logic              result_valid_o,
  output logic              manual_req_o,
  output logic [WORD_W-1:0] local_time_o
);
  logic                           shift;
  logic                           done;
  logic                           valid_q;
  logic [N_LANES-1:0]             ser;
  logic [N_LANES-1:0][WORD_W-1:0] words;

  assign ser[LANE_CLK]  = clk_bit_i;
  assign ser[LANE_CORR] = corr_bit_i;

  ptm_frame_ctrl #(.WORD_W(WORD_W)) i_frame (
    .clk_i, .rst_ni, .start_i, .ctx_valid_i,
    .shift_o(shift), .done_o(done)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    ptm_lane #(.WORD_W(WORD_W)) i_lane (
      .clk_i, .rst_ni, .shift_i(shift), .cap_i(done),
      .bit_i(ser[g]), .word_o(words[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= done;
  end

  ptm_req_gen #(.TMO_W(TMO_W)) i_req (
    .clk_i, .rst_ni, .cmd_i(manual_cmd_i), .rearm_i(valid_q),
    .timeout_i, .req_o(manual_req_o)
  );

  ptm_time_cnt #(.WORD_W(WORD_W), .LAT_CYC(LAT_CYC)) i_time (
    .clk_i, .rst_ni, .load_i(valid_q), .value_i(words[LANE_CLK]),
    .time_o(local_time_o)
  );

  assign clk_val_o      = words[LANE_CLK];
  assign corr_val_o     = words[LANE_CORR];
  assign result_valid_o = valid_q;

  assert_valid_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  assert_ctx_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctx_valid_i |=> !valid_q);
  assert_strobe_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !valid_q);
endmodule

// File: tb/test_ptm_deser.sv
module test_ptm_deser;
  localparam int unsigned W = 64;
  localparam int unsigned TW = 16;
  localparam int unsigned LAT = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctx = 1'b1, start = 1'b0, cb = 1'b0, rb = 1'b0, cmd = 1'b0;
  logic [TW-1:0] tmo = TW'(1000);
  logic [W-1:0] clk_val, corr_val, ltime;
  logic valid, req;

  int n_vec = 0;
  int n_bad = 0;
  logic [W-1:0] last_clk = '0, last_corr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptm_deser #(.WORD_W(W), .TMO_W(TW), .LAT_CYC(LAT)) i_ptm_deser (
    .clk_i(clk), .rst_ni(rst_n), .ctx_valid_i(ctx), .start_i(start),
    .clk_bit_i(cb), .corr_bit_i(rb), .manual_cmd_i(cmd), .timeout_i(tmo),
    .clk_val_o(clk_val), .corr_val_o(corr_val), .result_valid_o(valid),
    .manual_req_o(req), .local_time_o(ltime)
  );

  task automatic chk(input bit ok, input string req_tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  // drives n bits starting with a strobe; ctx drops from bit drop_at on (-1: never)
  task automatic drive_bits(input logic [W-1:0] a, input logic [W-1:0] b, input int n,
                            input int drop_at, input bit ctx0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(valid == 1'b0, "R2 no early valid", W'(valid), '0);
        chk(clk_val == last_clk, "R5 clk word held", clk_val, last_clk);
        chk(corr_val == last_corr, "R5 corr word held", corr_val, last_corr);
      end
      start = (i == 0);
      cb = a[i];
      rb = b[i];
      ctx = (i == 0) ? ctx0 : !(drop_at >= 0 && i >= drop_at);
    end
  endtask

  task automatic frame(input logic [W-1:0] a, input logic [W-1:0] b, input int drop_at,
                       input bit ctx0, input string tag);
    bit good;
    logic [W-1:0] tnow;
    good = ctx0 && drop_at < 0;
    drive_bits(a, b, W, drop_at, ctx0);
    @(negedge clk);
    start = 1'b0; ctx = 1'b1; cb = 1'b0; rb = 1'b0;
    if (good) begin
      chk(valid == 1'b1, {tag, " R2 valid"}, W'(valid), 1);
      chk(clk_val == a, {tag, " R2 clk word"}, clk_val, a);
      chk(corr_val == b, {tag, " R3 corr word"}, corr_val, b);
      last_clk = a; last_corr = b;
    end else begin
      chk(valid == 1'b0, {tag, " R4/R5 dropped"}, W'(valid), 0);
      chk(clk_val == last_clk, {tag, " R4 word kept"}, clk_val, last_clk);
    end
    @(negedge clk);
    chk(valid == 1'b0, {tag, " R2 single pulse"}, W'(valid), 0);
    if (good) chk(ltime == a + W'(LAT), {tag, " R11 load"}, ltime, a + W'(LAT));
    tnow = ltime;
    @(negedge clk);
    chk(ltime == tnow + 1, {tag, " R10 count"}, ltime, tnow + 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(valid == 0 && req == 0, "R1 flags", {62'd0, valid, req}, 0);
    chk(clk_val == 0 && corr_val == 0, "R1 words", clk_val | corr_val, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ltime == 1, "R1/R10 time from zero", ltime, 1);
  endtask

  task automatic t_frames();
    frame(64'hDEAD_BEEF_0123_4567, 64'h0000_0000_0000_00A5, -1, 1'b1, "basic");
    frame(64'h8000_0000_0000_0001, 64'hFFFF_0000_FFFF_0000, -1, 1'b1, "edges");
    frame(64'h1111_2222_3333_4444, 64'h5555, -1, 1'b0, "ctx_low_start");
    frame(64'h2222_3333_4444_5555, 64'h6666, 30, 1'b1, "ctx_drop_mid");
    frame(64'h3333_4444_5555_6666, 64'h7777, 63, 1'b1, "ctx_drop_last");
  endtask

  task automatic t_restart();
    drive_bits(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 40, -1, 1'b1);
    frame(64'h0F0F_F0F0_1234_ABCD, 64'h0000_1111_2222_3333, -1, 1'b1, "R6 restart");
  endtask

  task automatic t_req_frame();
    tmo = TW'(1000);
    @(negedge clk); cmd = 1'b1;
    @(negedge clk); cmd = 1'b0;
    chk(req == 1'b1, "R7 pulse", W'(req), 1);
    @(negedge clk);
    chk(req == 1'b0, "R7 single", W'(req), 0);
    cmd = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(req == 1'b0, "R8 ignored", W'(req), 0);
    end
    cmd = 1'b0;
    frame(64'hCAFE_0000_0000_0001, 64'h2, -1, 1'b1, "R8 rearm frame");
    cmd = 1'b1;
    @(negedge clk); cmd = 1'b0;
    chk(req == 1'b1, "R8 rearmed by frame", W'(req), 1);
  endtask

  task automatic t_req_timeout();
    tmo = TW'(8);
    repeat (20) @(negedge clk);
    cmd = 1'b1;
    @(negedge clk); cmd = 1'b0;
    chk(req == 1'b1, "R9 first", W'(req), 1);
    // edges after the request edge: k; re-armed after 8
    for (int k = 1; k <= 7; k++) begin
      cmd = 1'b1;
      @(negedge clk);
      chk(req == 1'b0, "R9 still blocked", W'(req), 0);
    end
    cmd = 1'b0;
    repeat (2) @(negedge clk);
    cmd = 1'b1;
    @(negedge clk); cmd = 1'b0;
    chk(req == 1'b1, "R9 rearmed by timeout", W'(req), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_frames();
    t_restart();
    t_req_frame();
    t_req_timeout();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule